// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block sits behind the control pins of a pipelined synchronous burst SRAM and settles, on each rising clock edge, which kind of cycle is being asked for: no access, sleep, deselect, a fresh access, a burst step or a burst pause. It also decides whether the cycle reads or writes. It then picks the word address to use. That address is either the one on the address pins, the next one in a four-word linear burst, or the one used last. The block drives per-lane write strobes into a small on-block word array and controls the tri-state enable of the read data bus.

Two address strobes can open an access. The processor-side strobe only counts while the first chip select is active, and an access it opens is always a read. The controller-side strobe opens a read or a write, depending on the write enables. Once an access is open, later cycles either step or hold the address, and each of them may read or write. Read data is registered and is presented one clock after its address is taken. The output enable works without the clock and is overridden whenever the present cycle writes.

Top module: `sbc_ctrl`

## Requirements
- R1: A cycle writes when `all_wr_n` is 0, or when `lane_wr_n` is 0 and at least one bit of `lane_en_n` is 0. Lane k (bits 8k+7..8k of the word) is written when `lane_strobe[k]` is 1. `lane_strobe` is 4'hF when `all_wr_n` is 0, ~`lane_en_n` for any other write, and 0 on any cycle that does not write.
- R2: An access opened by `cpu_strobe_n`=0 while `sel_a_n`=0 is a read whatever `all_wr_n`, `lane_wr_n` and `lane_en_n` say. Writes within that access can happen only on later cycles.
- R3: An access opened by either strobe, with the chip selected, takes its word address from `addr_in`.
- R4: With an access open and no strobe asserted, `burst_step_n`=0 uses the next burst address. The two low address bits count up by one and wrap from 3 to 0, and the upper bits stay unchanged.
- R5: With an access open, no strobe and `burst_step_n`=1, the same address as the previous cycle is used again.
- R6: A strobe while `sel_a_n`=1, `sel_b`=0 or `sel_c_n`=1 deselects the chip. No word is accessed, and later non-strobe cycles do nothing until a new access opens.
- R7: While `sleep` is 1, every other input is ignored. No word is read or written, and the burst address is kept.
- R8: The data of a read cycle appears on `rdata` after the next rising edge. `bus_drive` is 1 only while that data is valid and `out_en_n` is 0, and it follows `out_en_n` without waiting for a clock.
- R9: `bus_drive` is 0 during any cycle that writes, whatever `out_en_n` is.
- R10: Reset leaves the block deselected with `bus_drive` at 0. Non-strobe cycles before the first access write nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_a_n | input | 1 | First chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| burst_step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Per-lane write qualifier, active low |
| lane_en_n | input | 4 | Per-lane write selects, active low |
| sleep | input | 1 | Sleep request, active high |
| out_en_n | input | 1 | Output enable, active low, combinational |
| addr_in | input | 6 | External word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bus_drive | output | 1 | Read data bus drive enable |
| lane_strobe | output | 4 | Per-lane write strobes of the present cycle |

## Verification
The hardest case to reach is the one where a burst opened by the processor strobe carries active write enables on its opening edge. That edge must stay a read, and the very next burst step must write, with the bus masked only on that step. The stimulus opens such a burst with every write enable low, steps it once, and then reads the stepped word back through a fresh access. It also drives a pipelined read into a write cycle while the output enable is low, to check the mask. A four-step burst from a start address whose low bits are 2 runs the wrap from 3 to 0.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int LANES      = 4;
  localparam int LANE_W     = 8;
  localparam int BURST_BITS = 2;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_SLEEP,
    CYC_BEGIN,
    CYC_CONT,
    CYC_SUSP
  } cyc_kind_t;

  function automatic logic wants_write(input logic gw_n, input logic bwe_n,
                                       input logic [LANES-1:0] ln_n);
    return !gw_n || (!bwe_n && (ln_n != {LANES{1'b1}}));
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic gw_n,
                                                 input logic [LANES-1:0] ln_n);
    return gw_n ? ~ln_n : {LANES{1'b1}};
  endfunction

  function automatic logic [BURST_BITS-1:0] wrap_inc(input logic [BURST_BITS-1:0] v);
    return v + 1'b1;
  endfunction
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import sbc_pkg::*;
(
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             cpu_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             burst_step_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_en_n,
  input  logic             sleep,
  input  logic             active_q,
  output cyc_kind_t        kind,
  output logic             is_write,
  output logic             cpu_begin
);
  logic start_cpu, start_any, chip_on, req_wr;

  always_comb begin
    start_cpu = !cpu_strobe_n && !sel_a_n;
    start_any = start_cpu || !ctl_strobe_n;
    chip_on   = !sel_a_n && sel_b && !sel_c_n;
    req_wr    = wants_write(all_wr_n, lane_wr_n, lane_en_n);
    kind      = CYC_IDLE;
    is_write  = 1'b0;
    cpu_begin = 1'b0;
    if (sleep) begin
      kind = CYC_SLEEP;
    end else if (start_any) begin
      if (chip_on) begin
        kind      = CYC_BEGIN;
        cpu_begin = start_cpu;
        is_write  = start_cpu ? 1'b0 : req_wr;
      end else begin
        kind = CYC_DESEL;
      end
    end else if (active_q) begin
      kind     = burst_step_n ? CYC_SUSP : CYC_CONT;
      is_write = req_wr;
    end
  end
endmodule

// File: rtl/sbc_addr.sv
module sbc_addr
  import sbc_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_kind_t     kind,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] addr_q,
  output logic          active_q,
  output logic          access
);
  localparam int BB = BURST_BITS;

  always_comb begin
    access = (kind == CYC_BEGIN) || (kind == CYC_CONT) || (kind == CYC_SUSP);
    case (kind)
      CYC_BEGIN: eff_addr = addr_in;
      CYC_CONT:  eff_addr = {addr_q[AW-1:BB], wrap_inc(addr_q[BB-1:0])};
      default:   eff_addr = addr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      active_q <= 1'b0;
    end else begin
      case (kind)
        CYC_BEGIN: begin addr_q <= addr_in; active_q <= 1'b1; end
        CYC_CONT:  addr_q <= eff_addr;
        CYC_DESEL: active_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assert_begin_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_BEGIN) |=> (addr_q == $past(addr_in)));
  assert_burst_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_CONT) |=> (addr_q[BB-1:0] == $past(addr_q[BB-1:0]) + 1'b1)
                           && (addr_q[AW-1:BB] == $past(addr_q[AW-1:BB])));
  assert_suspend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_SUSP) |=> $stable(addr_q));
  assert_sleep_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_SLEEP) |=> ($stable(addr_q) && $stable(active_q)));
endmodule

// File: rtl/sbc_array.sv
module sbc_array
  import sbc_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        we,
  input  logic                    re,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata_q,
  output logic                    rd_valid_q
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = LANES * LANE_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (we[k]) mem[addr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
    end
    if (re) rdata_q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= re;
  end
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    cpu_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    burst_step_n,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic                    sleep,
  input  logic                    out_en_n,
  input  logic [AW-1:0]           addr_in,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    bus_drive,
  output logic [LANES-1:0]        lane_strobe
);
  cyc_kind_t     kind;
  logic          is_write, cpu_begin, active_q, access, rd_valid, wr_cycle;
  logic [AW-1:0] eff_addr, addr_q;

  sbc_decode u_dec (
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .burst_step_n(burst_step_n), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
    .lane_en_n(lane_en_n), .sleep(sleep), .active_q(active_q),
    .kind(kind), .is_write(is_write), .cpu_begin(cpu_begin)
  );

  sbc_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .kind(kind), .addr_in(addr_in),
    .eff_addr(eff_addr), .addr_q(addr_q), .active_q(active_q), .access(access)
  );

  assign wr_cycle    = access && is_write;
  assign lane_strobe = wr_cycle ? lane_mask(all_wr_n, lane_en_n) : '0;

  sbc_array #(.AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(lane_strobe), .re(access && !is_write),
    .addr(eff_addr), .wdata(wdata), .rdata_q(rdata), .rd_valid_q(rd_valid)
  );

  assign bus_drive = rd_valid && !out_en_n && !wr_cycle;

  assert_cpu_begin_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_begin |=> rd_valid);
  assert_deselect_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_DESEL) |=> (!rd_valid && !active_q));
  assert_no_strobe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !access |-> (lane_strobe == '0));
  assert_sleep_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rd_valid);
  assert_write_masks_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_strobe != '0) |-> !bus_drive);
endmodule

// File: tb/sim_sbc_ctrl.sv
`timescale 1ns/1ps
module sim_sbc_ctrl;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0;
  logic sel_a_n = 0, sel_b = 1, sel_c_n = 0, cpu_strobe_n = 1, ctl_strobe_n = 1;
  logic burst_step_n = 1, all_wr_n = 1, lane_wr_n = 1, sleep = 0, out_en_n = 0;
  logic [3:0] lane_en_n = 4'hF;
  logic [AW-1:0] addr_in = '0;
  logic [31:0] wdata = '0, rdata;
  logic bus_drive;
  logic [3:0] lane_strobe;

  always #2.5 clk = ~clk;

  sbc_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .burst_step_n(burst_step_n), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
    .lane_en_n(lane_en_n), .sleep(sleep), .out_en_n(out_en_n), .addr_in(addr_in),
    .wdata(wdata), .rdata(rdata), .bus_drive(bus_drive), .lane_strobe(lane_strobe)
  );

  typedef struct {
    logic        drive;
    logic [31:0] data;
    logic [3:0]  strobe;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;

  // reference state
  logic [31:0]   ref_mem [64];
  logic [AW-1:0] ref_addr = '0;
  bit            ref_open = 0;
  bit            ref_prev_rd = 0;
  logic [31:0]   ref_prev_data = '0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: one expected item per cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.req, "lane_strobe", {28'd0, lane_strobe}, {28'd0, e.strobe});
      check(e.req, "bus_drive", {31'd0, bus_drive}, {31'd0, e.drive});
      if (e.drive) check(e.req, "rdata", rdata, e.data);
    end
  end

  // driver: set pins for one cycle, predict, push expectation
  task automatic cyc(input logic sa, input logic sb, input logic sc,
                     input logic cpu, input logic ctl, input logic step,
                     input logic gw, input logic bwe, input logic [3:0] ln,
                     input logic slp, input logic oe, input logic [AW-1:0] a,
                     input logic [31:0] wd, input string req);
    bit wr, acc, wr_req, cpu_go, go, sel_ok;
    logic [AW-1:0] ea;
    logic [3:0] stb;
    exp_t e;
    @(posedge clk); #1;
    sel_a_n = sa; sel_b = sb; sel_c_n = sc; cpu_strobe_n = cpu; ctl_strobe_n = ctl;
    burst_step_n = step; all_wr_n = gw; lane_wr_n = bwe; lane_en_n = ln;
    sleep = slp; out_en_n = oe; addr_in = a; wdata = wd;

    wr_req = (gw == 1'b0) || (bwe == 1'b0 && ln != 4'b1111);
    cpu_go = (cpu == 1'b0) && (sa == 1'b0);
    go     = cpu_go || (ctl == 1'b0);
    sel_ok = (sa == 1'b0) && (sb == 1'b1) && (sc == 1'b0);
    acc = 0; wr = 0; ea = ref_addr;
    if (slp) begin
      acc = 0;
    end else if (go) begin
      if (sel_ok) begin
        acc = 1; ea = a; ref_open = 1;
        wr = cpu_go ? 0 : wr_req;
      end else ref_open = 0;
    end else if (ref_open) begin
      acc = 1; wr = wr_req;
      if (!step) ea = (ref_addr & ~6'd3) | ((ref_addr + 6'd1) & 6'd3);
    end
    stb = 4'b0000;
    if (acc && wr) stb = (gw == 1'b0) ? 4'b1111 : ~ln;
    e.drive  = ref_prev_rd && !oe && !(acc && wr);
    e.data   = ref_prev_data;
    e.strobe = stb;
    e.req    = req;
    q.push_back(e);
    // effects of the coming edge
    if (acc) ref_addr = ea;
    for (int k = 0; k < 4; k++) if (stb[k]) ref_mem[ea][8*k +: 8] = wd[8*k +: 8];
    ref_prev_rd = acc && !wr;
    if (acc && !wr) ref_prev_data = ref_mem[ea];
  endtask

  // shorthands
  task automatic idle(input string req);
    cyc(0,1,0, 1,1,1, 1,1,4'hF, 0,0, '0, '0, req);
  endtask
  task automatic cpu_read(input logic [AW-1:0] a, input logic gw, input string req);
    cyc(0,1,0, 0,1,1, gw,gw,4'h0, 0,0, a, 32'hDEAD_0000, req);
  endtask
  task automatic ctl_op(input logic [AW-1:0] a, input logic gw, input logic bwe,
                        input logic [3:0] ln, input logic [31:0] wd, input string req);
    cyc(0,1,0, 1,0,1, gw,bwe,ln, 0,0, a, wd, req);
  endtask
  task automatic step(input logic s, input logic gw, input logic oe,
                      input logic [31:0] wd, input string req);
    cyc(0,1,0, 1,1,s, gw,1,4'hF, 0,oe, '0, wd, req);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", "reset bus_drive", {31'd0, bus_drive}, 32'd0);
    check("R10", "reset lane_strobe", {28'd0, lane_strobe}, 32'd0);
    @(negedge clk); rst_n = 1;

    // R10: no access open, step with write enables gives nothing
    step(0, 0, 0, 32'h1111_1111, "R10");
    step(1, 0, 0, 32'h2222_2222, "R10");

    // fill array through controller-strobe writes (R1 full word, R3)
    for (int i = 0; i < 64; i++) ctl_op(i[AW-1:0], 0, 1, 4'hF, 32'h9E37_79B1 * (i + 1), "R3");
    idle("R3");

    // R8/R4/R5: processor read burst from 6 -> 7 -> 4 -> 5, then hold
    cpu_read(6'd6, 1, "R8");
    step(0, 1, 0, '0, "R4");
    step(0, 1, 0, '0, "R4");
    step(0, 1, 0, '0, "R4");
    step(1, 1, 0, '0, "R5");
    step(1, 1, 1, '0, "R8");   // output enable high: no drive
    step(1, 1, 0, '0, "R8");
    idle("R8");

    // R2: processor strobe with writes asserted still reads; next step writes
    cpu_read(6'd20, 0, "R2");
    step(0, 0, 0, 32'hCAFE_F00D, "R9");   // write cycle after read: masked
    cpu_read(6'd21, 1, "R2");
    idle("R2");
    cpu_read(6'd20, 1, "R2");
    idle("R2");

    // R1: lane writes
    ctl_op(6'd30, 1, 0, 4'b1010, 32'hAABB_CCDD, "R1");
    ctl_op(6'd31, 1, 0, 4'b1111, 32'h0BAD_0BAD, "R1");   // no lane: a read
    ctl_op(6'd30, 1, 1, 4'b0000, 32'h0, "R1");           // lane write off: read
    idle("R1");
    ctl_op(6'd33, 1, 0, 4'b0110, 32'h1234_5678, "R1");
    cpu_read(6'd33, 1, "R1");
    idle("R1");

    // R6: deselect by each chip select, then steps with writes do nothing
    cyc(0,0,0, 1,0,1, 0,1,4'hF, 0,0, 6'd40, 32'h5555_5555, "R6");
    step(0, 0, 0, 32'h6666_6666, "R6");
    cyc(0,1,1, 0,1,1, 0,1,4'hF, 0,0, 6'd41, 32'h7777_7777, "R6");
    step(1, 0, 0, 32'h8888_8888, "R6");
    cyc(1,1,0, 1,0,1, 0,1,4'hF, 0,0, 6'd42, 32'h9999_9999, "R6");
    step(0, 0, 0, 32'hAAAA_AAAA, "R6");
    cpu_read(6'd40, 1, "R6");
    step(0, 1, 0, '0, "R6");
    step(0, 1, 0, '0, "R6");
    idle("R6");

    // R7: sleep masks a begin write and a step
    cpu_read(6'd50, 1, "R7");
    cyc(0,1,0, 1,0,1, 0,1,4'hF, 1,0, 6'd12, 32'hFFFF_0000, "R7");
    cyc(0,1,0, 1,1,0, 0,1,4'hF, 1,0, 6'd12, 32'hFFFF_0001, "R7");
    step(1, 1, 0, '0, "R7");   // burst still at 50: re-read it
    cpu_read(6'd12, 1, "R7");
    idle("R7");
    idle("R7");

    repeat (2) @(posedge clk);
    @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL queue: actual %0d expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule